// File: doc/BRIEF.md
# Random Bitstream Zero-Run Extractor

This block holds a word of random bits and, each time a request arrives, reports how many 0 bits stand between the current read position and the next 1 bit. Bits are read starting at bit 0 of each loaded word and moving upward. The bits up to and including the 1 that was found are then consumed. Each result therefore uses up a variable number of bits. The results follow a geometric distribution, which a host uses to build non-uniform random variates.

A host processor supplies the words and collects the results. A word may carry fewer valid bits than the buffer width; bits above the valid length are never read. When the valid bits run out before a 1 is found, the zeros already counted are kept. The block then waits for the host to load a new word and continues counting in it. This repeats across any number of empty words until a 1 appears.

The count is held in a saturating register. If it saturates, a sticky overflow flag is raised. A low-water output tells the host early that the buffer is nearly used up, so that it can have the next word ready.

Top module: `zr_extract`

## Requirements
- R1: The result equals the number of 0 bits read before the next 1. Bits are read from bit 0 upward after each load, so a 1 at the read position gives 0.
- R2: After a result, the read position moves one past the 1 that was found. Later requests on the same word therefore return the gaps between successive 1 bits.
- R3: If no 1 remains in the unread bits, the number of unread zeros is carried over. After the next load, the result is that carried count plus the distance found in the new word.
- R4: Carrying over repeats across any number of loaded words that contain no 1. The result is the total of all zeros read.
- R5: `fill_cnt_i` gives the number of valid bits in a loaded word, counted from bit 0 (values above 64 count as 64). Bits at or above that count are ignored.
- R6: `fill_ready_o` is 1 exactly when no unread bits remain. While a request waits for a load, `res_valid_o` stays 0.
- R7: `fill_low_o` is 1 when the number of unread bits is at most LOW_MARK (default 8), and 0 otherwise.
- R8: A count above 65535 gives the result 65535 and sets `ovf_o`. `ovf_o` then stays 1 until reset, and later results are normal.
- R9: A result stays valid with unchanged data until it is taken with `res_ready_i`. `req_ready_o` is 0 while a request is pending or a result is waiting.
- R10: Synchronous reset (`rst` high) empties the buffer and clears the count, the overflow flag and the result. After reset, `fill_ready_o` = 1, `req_ready_o` = 1, `res_valid_o` = 0 and `ovf_o` = 0.
- R11: A load offered while `fill_ready_o` is 0 is ignored and leaves the buffer contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fill_valid_i | input | 1 | Host offers a new word |
| fill_data_i | input | 64 | Random word; bit 0 is read first |
| fill_cnt_i | input | 7 | Number of valid bits in the word, counted from bit 0 |
| fill_ready_o | output | 1 | Buffer is empty and can accept a word |
| fill_low_o | output | 1 | Unread bits are at or below the low-water mark |
| req_valid_i | input | 1 | Request for one zero-run value |
| req_ready_o | output | 1 | A request can be accepted |
| res_valid_o | output | 1 | Result is available |
| res_data_o | output | 16 | Zero-run length, saturated |
| res_ready_i | input | 1 | Host takes the result |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
A read position that is off by one shifts every later result for that word by one. It also moves the low-water output early or late, so the error shows on the very next result. A wrong carry-over or a mishandled valid length shows only on the first result after a load, so the bench places 1 bits on both sides of each word boundary and above each valid length. A flag that does not stay set, or a count that wraps instead of saturating, shows up at the overflow output and in the result that follows saturation. A result that is dropped or changed while it waits shows within the few cycles the bench holds it.

// File: rtl/zr_pkg.sv
package zr_pkg;
    localparam int ZR_BUF_W  = 64;
    localparam int ZR_ACC_W  = 16;
    localparam int ZR_LOW_MK = 8;
endpackage

// File: rtl/zr_scan.sv
module zr_scan #(
    parameter int W  = 64,
    parameter int PW = $clog2(W) + 1
) (
    input  logic [W-1:0]  bits_i,
    input  logic [PW-1:0] lo_i,
    input  logic [PW-1:0] hi_i,
    output logic          found_o,
    output logic [PW-1:0] pos_o
);
    logic [W-1:0] live;

    // keep only bits inside the unread window [lo, hi)
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign live[i] = bits_i[i] && (PW'(i) >= lo_i) && (PW'(i) < hi_i);
    end

    // lowest live bit wins
    always_comb begin
        found_o = |live;
        pos_o   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (live[i]) pos_o = PW'(i);
        end
    end
endmodule

// File: rtl/zr_satadd.sv
module zr_satadd #(
    parameter int AW = 16,
    parameter int IW = 7
) (
    input  logic [AW-1:0] base_i,
    input  logic [IW-1:0] inc_i,
    output logic [AW-1:0] sum_o,
    output logic          sat_o
);
    logic [AW:0] wide;

    always_comb begin
        wide  = {1'b0, base_i} + (AW+1)'(inc_i);
        sat_o = wide[AW];
        sum_o = wide[AW] ? '1 : wide[AW-1:0];
    end
endmodule

// File: rtl/zr_extract.sv
module zr_extract
    import zr_pkg::*;
#(
    parameter int BUF_W    = ZR_BUF_W,
    parameter int ACC_W    = ZR_ACC_W,
    parameter int LOW_MARK = ZR_LOW_MK,
    parameter int PW       = $clog2(BUF_W) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_valid_i,
    input  logic [BUF_W-1:0] fill_data_i,
    input  logic [PW-1:0]    fill_cnt_i,
    output logic             fill_ready_o,
    output logic             fill_low_o,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    output logic             res_valid_o,
    output logic [ACC_W-1:0] res_data_o,
    input  logic             res_ready_i,
    output logic             ovf_o
);
    typedef struct packed {
        logic [BUF_W-1:0] bits;
        logic [PW-1:0]    rd;
        logic [PW-1:0]    last;
        logic [ACC_W-1:0] acc;
        logic             pend;
        logic             res_valid;
        logic [ACC_W-1:0] res;
        logic             ovf;
    } zr_state_t;

    zr_state_t st_q, st_d;

    logic [PW-1:0]    unread;
    logic             empty;
    logic             hit;
    logic [PW-1:0]    hit_pos;
    logic [PW-1:0]    inc;
    logic [ACC_W-1:0] sum;
    logic             sat;
    logic             fill_take, req_take, res_take;
    logic [PW-1:0]    cnt_clamped;

    zr_scan #(.W(BUF_W), .PW(PW)) u_scan (
        .bits_i (st_q.bits),
        .lo_i   (st_q.rd),
        .hi_i   (st_q.last),
        .found_o(hit),
        .pos_o  (hit_pos)
    );

    zr_satadd #(.AW(ACC_W), .IW(PW)) u_add (
        .base_i(st_q.acc),
        .inc_i (inc),
        .sum_o (sum),
        .sat_o (sat)
    );

    always_comb begin
        unread      = st_q.last - st_q.rd;
        empty       = (st_q.rd == st_q.last);
        fill_take   = fill_valid_i && empty;
        req_take    = req_valid_i && !st_q.pend && !st_q.res_valid;
        res_take    = st_q.res_valid && res_ready_i;
        inc         = hit ? (hit_pos - st_q.rd) : unread;
        cnt_clamped = (fill_cnt_i > PW'(BUF_W)) ? PW'(BUF_W) : fill_cnt_i;

        st_d = st_q;
        if (res_take) st_d.res_valid = 1'b0;
        if (req_take) st_d.pend = 1'b1;
        if (st_q.pend) begin
            if (hit) begin
                st_d.res       = sum;
                st_d.res_valid = 1'b1;
                st_d.acc       = '0;
                st_d.rd        = hit_pos + PW'(1);
                st_d.pend      = 1'b0;
            end else begin
                st_d.acc = sum;
                st_d.rd  = st_q.last;
            end
            if (sat) st_d.ovf = 1'b1;
        end
        // a load only happens on an empty buffer, so it never races a hit
        if (fill_take) begin
            st_d.bits = fill_data_i;
            st_d.rd   = '0;
            st_d.last = cnt_clamped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fill_ready_o = empty;
    assign fill_low_o   = (unread <= PW'(LOW_MARK));
    assign req_ready_o  = !st_q.pend && !st_q.res_valid;
    assign res_valid_o  = st_q.res_valid;
    assign res_data_o   = st_q.res;
    assign ovf_o        = st_q.ovf;

    AST_SCAN_HIT: assert property (@(posedge clk) disable iff (rst)
        hit |-> (st_q.bits[hit_pos[PW-2:0]] && hit_pos >= st_q.rd && hit_pos < st_q.last)); // R1
    AST_RD_BOUND: assert property (@(posedge clk) disable iff (rst)
        st_q.rd <= st_q.last); // R2
    AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o))); // R9
    AST_REQ_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o) |=> !req_ready_o); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o); // R8
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_o) |-> ((res_valid_o && res_data_o == '1) || st_q.acc == '1)); // R8
endmodule

// File: tb/tb_zr_extract.sv
module tb_zr_extract;
    logic        clk = 0;
    logic        rst = 1;
    logic        fill_valid_i = 0;
    logic [63:0] fill_data_i = '0;
    logic [6:0]  fill_cnt_i = '0;
    logic        fill_ready_o, fill_low_o;
    logic        req_valid_i = 0;
    logic        req_ready_o;
    logic        res_valid_o;
    logic [15:0] res_data_o;
    logic        res_ready_i = 1;
    logic        ovf_o;

    int checks = 0;
    int errors = 0;

    typedef struct { logic [63:0] d; int n; } fill_t;
    typedef struct { int v; string tag; } exp_t;
    fill_t fq[$];
    exp_t  eq[$];
    bit    bq[$];
    logic  inject = 0;
    logic [63:0] inj_data = '0;

    always #5 clk = ~clk;

    zr_extract dut (
        .clk(clk), .rst(rst),
        .fill_valid_i(fill_valid_i), .fill_data_i(fill_data_i), .fill_cnt_i(fill_cnt_i),
        .fill_ready_o(fill_ready_o), .fill_low_o(fill_low_o),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .res_valid_o(res_valid_o), .res_data_o(res_data_o), .res_ready_i(res_ready_i),
        .ovf_o(ovf_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int take_expected();
        int z = 0;
        while (bq.size() > 0 && bq[0] == 1'b0) begin
            void'(bq.pop_front());
            z++;
        end
        if (bq.size() > 0) void'(bq.pop_front());
        return (z > 65535) ? 65535 : z;
    endfunction

    task automatic push_fill(input logic [63:0] d, input int n);
        fill_t f;
        f.d = d; f.n = n;
        fq.push_back(f);
        for (int i = 0; i < ((n > 64) ? 64 : n); i++) bq.push_back(d[i]);
    endtask

    task automatic send_req();
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_valid_i = 1;
        @(negedge clk);
        req_valid_i = 0;
    endtask

    task automatic do_req(input string tag);
        exp_t e;
        e.v = take_expected(); e.tag = tag;
        eq.push_back(e);
        send_req();
    endtask

    task automatic drain();
        while (eq.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_reset();
        fq.delete(); eq.delete(); bq.delete();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    // host model: loads queued words whenever the buffer is empty
    always @(negedge clk) begin
        if (inject) begin
            fill_valid_i = 1; fill_data_i = inj_data; fill_cnt_i = 7'd64;
        end else if (!rst && fq.size() > 0 && fill_ready_o) begin
            fill_t f;
            f = fq.pop_front();
            fill_valid_i = 1; fill_data_i = f.d; fill_cnt_i = 7'(f.n);
        end else begin
            fill_valid_i = 0;
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && res_valid_o && res_ready_i) begin
            if (eq.size() == 0) begin
                check(0, "unexpected result", int'(res_data_o), -1);
            end else begin
                exp_t e;
                e = eq.pop_front();
                check(int'(res_data_o) == e.v, e.tag, int'(res_data_o), e.v);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] held;
        do_reset();
        // R10 reset state
        check(res_valid_o == 0, "R10 res_valid after reset", res_valid_o, 0);
        check(ovf_o == 0, "R10 ovf after reset", ovf_o, 0);
        check(fill_ready_o == 1, "R10 fill_ready after reset", fill_ready_o, 1);
        check(req_ready_o == 1, "R10 req_ready after reset", req_ready_o, 1);
        check(fill_low_o == 1, "R7 low flag when empty", fill_low_o, 1);

        // R6: request with empty buffer stalls until a load
        send_req();
        repeat (10) @(negedge clk);
        check(res_valid_o == 0, "R6 no result while empty", res_valid_o, 0);
        check(fill_ready_o == 1, "R6 fill_ready while empty", fill_ready_o, 1);
        push_fill((64'd1 << 60) | (64'd1 << 5) | 64'd3, 64);
        begin
            exp_t e;
            e.v = take_expected(); e.tag = "R1 immediate one gives 0";
            eq.push_back(e);
        end
        drain();
        // R2: successive gaps
        do_req("R2 adjacent one gives 0");
        do_req("R2 gap to bit 5");
        drain();
        check(fill_low_o == 0, "R7 low flag with 58 unread", fill_low_o, 0);
        do_req("R2 gap to bit 60");
        drain();
        check(fill_low_o == 1, "R7 low flag with 3 unread", fill_low_o, 1);

        // R11: load offered while not empty is ignored
        check(fill_ready_o == 0, "R11 fill_ready low with unread bits", fill_ready_o, 0);
        inj_data = '1; inject = 1;
        @(negedge clk); inject = 0;
        // R3: carried zeros plus distance in next word
        push_fill(64'd1 << 4, 64);
        do_req("R3 R11 carry across load");
        drain();

        // R5: valid length limits reading
        push_fill(64'hFFFF_FFFF_FFFF_FC20, 10);
        push_fill(64'd1 << 3, 64);
        do_req("R5 run ending at bit 5 of short word");
        do_req("R5 bits above length ignored");
        drain();

        // R4: several empty words in a row
        push_fill(64'd0, 64);
        push_fill(64'd0, 64);
        push_fill(64'd0, 64);
        push_fill(64'd1 << 7, 64);
        do_req("R4 carry across three empty words");
        drain();

        // R9: result held until taken
        res_ready_i = 0;
        push_fill(64'd1 << 9, 64);
        do_req("R9 held result value");
        while (!res_valid_o) @(negedge clk);
        held = res_data_o;
        repeat (5) @(negedge clk);
        check(res_valid_o == 1, "R9 valid held", res_valid_o, 1);
        check(res_data_o == held, "R9 data stable", int'(res_data_o), int'(held));
        check(req_ready_o == 0, "R9 req_ready low while result waits", req_ready_o, 0);
        res_ready_i = 1;
        drain();

        // R8: saturation and sticky flag
        check(ovf_o == 0, "R8 no overflow before long run", ovf_o, 0);
        for (int k = 0; k < 1025; k++) push_fill(64'd0, 64);
        push_fill(64'd1, 64);
        do_req("R8 saturated result");
        drain();
        check(ovf_o == 1, "R8 overflow set", ovf_o, 1);
        push_fill(64'd1 << 2, 64);
        do_req("R8 normal result after saturation");
        drain();
        check(ovf_o == 1, "R8 overflow sticky", ovf_o, 1);

        do_reset();
        check(ovf_o == 0, "R10 overflow cleared by reset", ovf_o, 0);
        check(fill_ready_o == 1, "R10 buffer empty after reset", fill_ready_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule